// File: doc/BRIEF.md
# Execute Stage with Branch Resolution

This block is the execute step of a simple in-order processor core. It receives the decoded instruction class and function code together with the operand values read in decode. These are the two register operands, the immediate or destination constant, the fall-through address and the value returned by a memory read. From them it forms the ALU result used for write-back and memory addressing. It also decides whether a conditional jump is taken and supplies the address of the next instruction.

All datapath outputs are combinational in the same cycle as their inputs. The only state is a three-flag register holding zero, sign and overflow. Only arithmetic/logic instructions write this register, at the clock edge that ends their cycle. Conditional jumps read the flags already stored, so a jump sees the flags left by the most recent earlier arithmetic instruction.

Top module: `exec_stage`

## Requirements
- R1: For non-arithmetic classes, `val_e = val_b + X` (modulo 2^W), where the class code `icode` selects X. X is `val_a` for register move (2). X is `val_c` for immediate move (3), store (4) and load (5). X is −4 for call (8) and push (10), and +4 for return (9) and pop (11). X is 0 for every other code (0, 1, 7, 12–15).
- R2: For the arithmetic class (`icode` 6), `ifun` selects the operation. 0 gives `val_b + val_a`, 1 gives `val_b - val_a`, 2 gives `val_b & val_a` and 3 gives `val_b ^ val_a`. Codes 4–15 give the sum.
- R3: `flags` is `{ZF, SF, OF}` and resets synchronously to 3'b100. It takes a new value only at a rising edge where `icode` is 6 and reset is low. During the arithmetic cycle itself it still shows the old value.
- R4: On an arithmetic load, ZF is 1 exactly when the result is zero, and SF is the result's top bit. OF is signed overflow of the add or subtract, and OF is 0 for AND and XOR.
- R5: When `icode` is 7, `taken` is evaluated from the stored flags by `ifun`. The codes are 0 always, 1 (SF^OF)|ZF, 2 SF^OF, 3 ZF, 4 ~ZF, 5 ~(SF^OF) and 6 ~(SF^OF)&~ZF. Codes 7–15 are never taken. `taken` is 0 for every other class.
- R6: For a jump, `next_pc` is `val_c` when taken and `val_p` otherwise. For a call (8), `next_pc` is `val_c`.
- R7: For a return (9), `next_pc` is `val_m`. For all remaining classes, `next_pc` is `val_p`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset |
| icode | input | 4 | Instruction class code |
| ifun | input | 4 | Function code within the class |
| val_a | input | W | First register operand |
| val_b | input | W | Second register operand |
| val_c | input | W | Immediate or destination constant |
| val_p | input | W | Fall-through address |
| val_m | input | W | Value loaded from memory (return address) |
| val_e | output | W | ALU result |
| flags | output | 3 | Stored {ZF, SF, OF} |
| taken | output | 1 | Jump condition holds |
| next_pc | output | W | Address of the next instruction |

## Verification
The bench drives arithmetic operands chosen to reach each reachable flag combination. These include a zero result with overflow, positive overflow and a negative carry-free sum. For each combination it sweeps all sixteen jump function codes. A swapped less/greater term or a missing overflow term would therefore mispredict at least one jump. Subtraction is checked with operands in both orders, which exposes a design that computes `val_a - val_b`. The bench also checks that flags neither change during the arithmetic cycle nor move on any other class. A design that loads flags on stack or address arithmetic would corrupt the later jump decisions. Every class code, including the unused ones, is swept against the ±4 stack constants and the next-PC rules.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam logic [3:0] IC_HALT  = 4'd0;
  localparam logic [3:0] IC_NOP   = 4'd1;
  localparam logic [3:0] IC_RRMOV = 4'd2;
  localparam logic [3:0] IC_IRMOV = 4'd3;
  localparam logic [3:0] IC_RMMOV = 4'd4;
  localparam logic [3:0] IC_MRMOV = 4'd5;
  localparam logic [3:0] IC_ARITH = 4'd6;
  localparam logic [3:0] IC_JUMP  = 4'd7;
  localparam logic [3:0] IC_CALL  = 4'd8;
  localparam logic [3:0] IC_RET   = 4'd9;
  localparam logic [3:0] IC_PUSH  = 4'd10;
  localparam logic [3:0] IC_POP   = 4'd11;

  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_SUB = 2'd1;
  localparam logic [1:0] FN_AND = 2'd2;
  localparam logic [1:0] FN_XOR = 2'd3;

  localparam int STACK_STEP = 4;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   icode,
  input  logic [3:0]   ifun,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic [W-1:0] val_c,
  output logic [W-1:0] val_e,
  output flags_t       new_flags,
  output logic         is_arith
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] STEP = W'(STACK_STEP);

  logic [W-1:0] opa;
  logic [1:0]   fun;
  logic         ovf;

  always_comb begin
    unique case (icode)
      IC_RRMOV, IC_ARITH:          opa = val_a;
      IC_IRMOV, IC_RMMOV, IC_MRMOV: opa = val_c;
      IC_CALL, IC_PUSH:            opa = -STEP;
      IC_RET, IC_POP:              opa = STEP;
      default:                     opa = '0;
    endcase
  end

  assign is_arith = (icode == IC_ARITH);
  assign fun = (is_arith && ifun[3:2] == 2'b00) ? ifun[1:0] : FN_ADD;

  always_comb begin
    ovf = 1'b0;
    unique case (fun)
      FN_SUB: begin
        val_e = val_b - opa;
        ovf   = (opa[MSB] != val_b[MSB]) && (val_e[MSB] != val_b[MSB]);
      end
      FN_AND: val_e = val_b & opa;
      FN_XOR: val_e = val_b ^ opa;
      default: begin
        val_e = val_b + opa;
        ovf   = (opa[MSB] == val_b[MSB]) && (val_e[MSB] != val_b[MSB]);
      end
    endcase
  end

  assign new_flags = '{zf: (val_e == '0), sf: val_e[MSB], of: ovf};
endmodule

// File: rtl/exec_cc.sv
module exec_cc
  import exec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= FLAGS_RESET;
    else if (load) q <= d;
  end

  p_cc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> q == $past(q));
  p_cc_load_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));
endmodule

// File: rtl/exec_branch.sv
module exec_branch
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   icode,
  input  logic [3:0]   ifun,
  input  flags_t       cc,
  input  logic [W-1:0] val_c,
  input  logic [W-1:0] val_p,
  input  logic [W-1:0] val_m,
  output logic         taken,
  output logic [W-1:0] next_pc
);
  logic lt;
  logic cond;

  assign lt = cc.sf ^ cc.of;

  always_comb begin
    unique case (ifun)
      4'd0:    cond = 1'b1;
      4'd1:    cond = lt | cc.zf;
      4'd2:    cond = lt;
      4'd3:    cond = cc.zf;
      4'd4:    cond = ~cc.zf;
      4'd5:    cond = ~lt;
      4'd6:    cond = ~lt & ~cc.zf;
      default: cond = 1'b0;
    endcase
  end

  assign taken = (icode == IC_JUMP) && cond;

  always_comb begin
    unique case (icode)
      IC_JUMP: next_pc = taken ? val_c : val_p;
      IC_CALL: next_pc = val_c;
      IC_RET:  next_pc = val_m;
      default: next_pc = val_p;
    endcase
  end
endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   icode,
  input  logic [3:0]   ifun,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic [W-1:0] val_c,
  input  logic [W-1:0] val_p,
  input  logic [W-1:0] val_m,
  output logic [W-1:0] val_e,
  output logic [2:0]   flags,
  output logic         taken,
  output logic [W-1:0] next_pc
);
  flags_t alu_flags;
  flags_t cc_q;
  logic   load_cc;

  exec_alu #(.W(W)) u_alu (
    .icode(icode), .ifun(ifun), .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .val_e(val_e), .new_flags(alu_flags), .is_arith(load_cc)
  );

  exec_cc u_cc (
    .clk(clk), .rst(rst), .load(load_cc), .d(alu_flags), .q(cc_q)
  );

  exec_branch #(.W(W)) u_br (
    .icode(icode), .ifun(ifun), .cc(cc_q), .val_c(val_c), .val_p(val_p),
    .val_m(val_m), .taken(taken), .next_pc(next_pc)
  );

  assign flags = cc_q;

  p_push_step_r1: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_PUSH) |-> val_e == val_b - W'(STACK_STEP));
  p_uncond_r5: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_JUMP && ifun == 4'd0) |-> taken);
  p_nojump_r5: assert property (@(posedge clk) disable iff (rst)
    (icode != IC_JUMP) |-> !taken);
  p_call_pc_r6: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_CALL) |-> next_pc == val_c);
  p_fall_pc_r6: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_JUMP && !taken) |-> next_pc == val_p);
  p_ret_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (icode == IC_RET) |-> next_pc == val_m);
endmodule

// File: tb/tb_exec_stage.sv
`timescale 1ns/1ps
module tb_exec_stage;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] icode = 4'd1, ifun = 4'd0;
  logic [W-1:0] val_a = '0, val_b = '0, val_c = '0, val_p = '0, val_m = '0;
  logic [W-1:0] val_e, next_pc;
  logic [2:0] flags;
  logic taken;
  int n_chk = 0, n_bad = 0;
  logic [2:0] exp_fl;
  logic [W-1:0] pa [8];
  logic [W-1:0] pb [8];
  logic [W-1:0] ja [6];
  logic [W-1:0] jb [6];
  logic [3:0]   jf [6];

  always #2.5 clk = ~clk;

  exec_stage #(.W(W)) dut (
    .clk(clk), .rst(rst), .icode(icode), .ifun(ifun), .val_a(val_a),
    .val_b(val_b), .val_c(val_c), .val_p(val_p), .val_m(val_m),
    .val_e(val_e), .flags(flags), .taken(taken), .next_pc(next_pc)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model_e(input logic [3:0] ic, input logic [3:0] fn,
                                           input logic [W-1:0] a, b, c);
    case (ic)
      4'd2: return b + a;
      4'd3, 4'd4, 4'd5: return b + c;
      4'd8, 4'd10: return b - 32'd4;
      4'd9, 4'd11: return b + 32'd4;
      4'd6: case (fn)
        4'd1: return b - a;
        4'd2: return b & a;
        4'd3: return b ^ a;
        default: return b + a;
      endcase
      default: return b;
    endcase
  endfunction

  function automatic logic [2:0] model_fl(input logic [3:0] fn, input logic [W-1:0] a, b);
    logic [W-1:0] r;
    longint sa, sb, full;
    logic of;
    r = model_e(4'd6, fn, a, b, '0);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (fn == 4'd2 || fn == 4'd3) of = 1'b0;
    else begin
      full = (fn == 4'd1) ? sb - sa : sb + sa;
      of = (full != longint'($signed(r)));
    end
    return {r == '0, r[W-1], of};
  endfunction

  function automatic logic model_cond(input logic [3:0] fn, input logic [2:0] f);
    logic z, neg;
    z = f[2];
    neg = (f[1] != f[0]);
    case (fn)
      4'd0: return 1'b1;
      4'd1: return neg || z;
      4'd2: return neg;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !neg;
      4'd6: return !neg && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_op(input logic [3:0] fn, input logic [W-1:0] a, b);
    icode = 4'd6; ifun = fn; val_a = a; val_b = b;
    #1;
    chk("R2 arith result", val_e, model_e(4'd6, fn, a, b, '0));
    chk("R3 flags unchanged during arith cycle", {29'd0, flags}, {29'd0, exp_fl});
    @(negedge clk);
    exp_fl = model_fl(fn, a, b);
    chk("R4 flags after arith", {29'd0, flags}, {29'd0, exp_fl});
    icode = 4'd1; ifun = 4'd0;
  endtask

  initial begin
    pa = '{32'd5, 32'd7, 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h1234_5678, 32'd0, 32'h8000_0000};
    pb = '{32'd7, 32'd5, 32'd1, 32'hffff_ffff, 32'hffff_ffff, 32'h1234_5678, 32'd0, 32'h7fff_ffff};
    ja = '{32'd1, 32'd1, 32'd1, 32'hffff_ffff, 32'h5a5a_5a5a, 32'h8000_0000};
    jb = '{32'd2, 32'd0, 32'h7fff_ffff, 32'h8000_0000, 32'h5a5a_5a5a, 32'h8000_0000};
    jf = '{4'd0, 4'd1, 4'd0, 4'd0, 4'd3, 4'd0};
    exp_fl = 3'b100;
    repeat (3) @(negedge clk);
    chk("R3 reset flags", {29'd0, flags}, 32'd4);
    rst = 1'b0;
    @(negedge clk);

    for (int ic = 0; ic < 16; ic++) begin
      if (ic == 6 || ic == 7) continue;
      for (int k = 0; k < 3; k++) begin
        icode = 4'(ic); ifun = 4'(k * 5);
        val_a = 32'h1111_0001 * (k + 1); val_b = 32'hf000_0002 + k;
        val_c = 32'h0000_4000 + k; val_p = 32'h0000_0100 + k; val_m = 32'hcafe_0000 + k;
        #1;
        chk("R1 operand select", val_e, model_e(4'(ic), 4'(k * 5), val_a, val_b, val_c));
        chk("R5 taken low outside jumps", {31'd0, taken}, 32'd0);
        if (ic == 8) chk("R6 call target", next_pc, val_c);
        else if (ic == 9) chk("R7 return target", next_pc, val_m);
        else chk("R7 fall through", next_pc, val_p);
        @(negedge clk);
        chk("R3 flags held on non-arith", {29'd0, flags}, {29'd0, exp_fl});
      end
    end

    for (int fn = 0; fn < 6; fn++)
      for (int k = 0; k < 8; k++)
        run_op(4'(fn), pa[k], pb[k]);

    for (int s = 0; s < 6; s++) begin
      run_op(jf[s], ja[s], jb[s]);
      for (int fn = 0; fn < 16; fn++) begin
        icode = 4'd7; ifun = 4'(fn); val_c = 32'h0000_9000 + fn; val_p = 32'h0000_0200 + fn;
        #1;
        chk("R5 jump condition", {31'd0, taken}, {31'd0, model_cond(4'(fn), exp_fl)});
        chk("R6 jump target", next_pc, model_cond(4'(fn), exp_fl) ? val_c : val_p);
        @(negedge clk);
        chk("R3 flags held on jump", {29'd0, flags}, {29'd0, exp_fl});
      end
    end

    run_op(4'd0, 32'h7fff_ffff, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_fl = 3'b100;
    chk("R3 reset reloads flags", {29'd0, flags}, 32'd4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule